// File: doc/BRIEF.md
# Affinity-Constrained Counter Allocator

This block hands out performance counters to event requests. There are ten counters. Each 8-bit event code has an eligibility mask that lists the counters allowed to count that event. The block keeps a mask of the counters currently in use. For each request it grants the eligible free counter with the lowest index and marks that counter used. If no eligible counter is free, it reports failure.

A separate release port frees a counter by its index. A release and a request may arrive in the same cycle, and both take effect. The result of a request is registered and appears one cycle later, together with the updated used mask. The block places each request on its own and does not rearrange requests to fit the most constrained events first.

Top module: `ctr_alloc`

## Requirements
- R1: While reset is held low, and in the first cycle after it is released, `used_mask` is all zero and `gnt_valid`, `gnt_fail` and `gnt_idx` are all zero.
- R2: An event code with no special rule below may use counters 2 to 9 and never counter 0 or 1.
- R3: Event code 0x02 may use counter 0 as well as counters 2 to 9.
- R4: Event code 0x8c may use only counters 1 and 7.
- R5: Event codes 0x8d, 0x8e, 0x8f, 0x90, 0x93, 0x94, 0x95, 0x98, 0x99, 0x9c, 0xbf, 0xc0, 0xc1, 0xc4, 0xc5, 0xc6, 0xc8, 0xca and 0xcb may use only counters 5, 6 and 7.
- R6: Event codes 0x01, 0x96, 0x97, 0x9a, 0x9b and 0x9f may use only counter 7.
- R7: Event codes 0xf5, 0xf6, 0xf7 and 0xfd may use only counters 2, 4 and 6. Event code 0xf8 may use only counters 2 to 7.
- R8: A request is granted the lowest-indexed counter that is eligible and free. Bit i of `used_mask` stands for counter i. The granted bit is set in `used_mask` in the same cycle that the grant appears.
- R9: If no eligible counter is free, the block raises `gnt_fail` for one cycle with `gnt_valid` low, and the request sets no bit of `used_mask`.
- R10: A release with an index from 0 to 9 clears that bit of `used_mask`. A release with an index from 10 to 15 is ignored.
- R11: When a request and a release arrive in the same cycle, the request is judged against the mask as it stood before the release. If both target the same index, the bit ends up set.
- R12: The grant or failure for a request appears exactly one clock edge after the request is sampled. In any cycle that follows a cycle with no request, `gnt_valid` and `gnt_fail` are low and `gnt_idx` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Allocation request strobe |
| req_event | input | 8 | Event code of the request |
| rel_valid | input | 1 | Release strobe |
| rel_idx | input | 4 | Index of the counter to free |
| gnt_valid | output | 1 | Grant succeeded (one-cycle pulse) |
| gnt_idx | output | 4 | Granted counter index, zero when no grant |
| gnt_fail | output | 1 | No eligible free counter (one-cycle pulse) |
| used_mask | output | 10 | Counters currently allocated |

## Verification
A wrong bit in the used mask shows on `used_mask` at the very next edge. If a bit is set that should not be, later requests skip a free counter or fail while a counter is still free. If a bit is lost, two requests are granted the same index. A wrong eligibility entry shows on the first request for that code, either as a forbidden index or as a wrong failure. So every grant is compared each cycle against a reference that keeps its own used set. That comparison covers empty, partly full and full masks, and cycles where a release and a request arrive together.

// File: rtl/ctr_alloc.sv
module ctr_alloc #(
  parameter int NCTR = 10,
  parameter int IDXW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [7:0]      req_event,
  input  logic            rel_valid,
  input  logic [IDXW-1:0] rel_idx,
  output logic            gnt_valid,
  output logic [IDXW-1:0] gnt_idx,
  output logic            gnt_fail,
  output logic [NCTR-1:0] used_mask
);

  function automatic logic [NCTR-1:0] eligible(input logic [7:0] ev);
    logic [9:0] m;
    case (ev)
      8'h01, 8'h96, 8'h97, 8'h9a, 8'h9b, 8'h9f: m = 10'h080;
      8'h02:                                    m = 10'h3fd;
      8'h8c:                                    m = 10'h082;
      8'h8d, 8'h8e, 8'h8f, 8'h90, 8'h93, 8'h94, 8'h95, 8'h98, 8'h99, 8'h9c,
      8'hbf, 8'hc0, 8'hc1, 8'hc4, 8'hc5, 8'hc6, 8'hc8, 8'hca, 8'hcb:
                                                m = 10'h0e0;
      8'hf5, 8'hf6, 8'hf7, 8'hfd:               m = 10'h054;
      8'hf8:                                    m = 10'h0fc;
      default:                                  m = 10'h3fc;
    endcase
    return NCTR'(m);
  endfunction

  logic [NCTR-1:0] cand, take, drop, used_next;
  logic [IDXW-1:0] pick;
  logic            found, grant, rel_ok;

  assign cand = eligible(req_event) & ~used_mask;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NCTR - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        pick  = IDXW'(i);
      end
    end
  end

  assign grant     = req_valid && found;
  assign rel_ok    = rel_valid && (int'(rel_idx) < NCTR);
  assign take      = grant  ? (NCTR'(1) << pick)    : '0;
  assign drop      = rel_ok ? (NCTR'(1) << rel_idx) : '0;
  assign used_next = (used_mask & ~drop) | take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_valid <= 1'b0;
      gnt_fail  <= 1'b0;
      gnt_idx   <= '0;
      used_mask <= '0;
    end else begin
      gnt_valid <= grant;
      gnt_fail  <= req_valid && !found;
      gnt_idx   <= grant ? pick : '0;
      used_mask <= used_next;
    end
  end

endmodule

// File: rtl/ctr_alloc_chk.sv
module ctr_alloc_chk #(
  parameter int NCTR = 10,
  parameter int IDXW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            rel_valid,
  input logic            gnt_valid,
  input logic            gnt_fail,
  input logic [IDXW-1:0] gnt_idx,
  input logic [NCTR-1:0] used_mask
);

  // R12
  gnt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gnt_valid && gnt_fail));

  // R12
  gnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> (!gnt_valid && !gnt_fail));

  // R8
  gnt_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (!(|($past(used_mask) & (NCTR'(1) << gnt_idx)))
                   && (|(used_mask & (NCTR'(1) << gnt_idx)))));

  // R8
  gnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (int'(gnt_idx) < NCTR));

  // R9
  fail_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_fail |-> ((used_mask & ~$past(used_mask)) == '0));

  // R10
  clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(used_mask) & ~used_mask) != '0) |->
      ($past(rel_valid) && $countones($past(used_mask) & ~used_mask) == 1));

  // R8
  set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((used_mask & ~$past(used_mask)) != '0) |->
      (gnt_valid && $countones(used_mask & ~$past(used_mask)) == 1));

endmodule

bind ctr_alloc ctr_alloc_chk #(.NCTR(NCTR), .IDXW(IDXW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rel_valid(rel_valid),
  .gnt_valid(gnt_valid), .gnt_fail(gnt_fail), .gnt_idx(gnt_idx),
  .used_mask(used_mask)
);

// File: tb/ctr_alloc_test.sv
module ctr_alloc_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       req_valid = 0;
  logic [7:0] req_event = 0;
  logic       rel_valid = 0;
  logic [3:0] rel_idx = 0;
  logic       gnt_valid, gnt_fail;
  logic [3:0] gnt_idx;
  logic [9:0] used_mask;

  int checks = 0;
  int errors = 0;
  logic [9:0] mused = 0;

  always #5 clk = ~clk;

  ctr_alloc uut (.*);

  function automatic logic [9:0] ref_aff(input logic [7:0] ev);
    logic [7:0] only7[$] = '{8'h01, 8'h96, 8'h97, 8'h9a, 8'h9b, 8'h9f};
    logic [7:0] trio[$] = '{8'h8d, 8'h8e, 8'h8f, 8'h90, 8'h93, 8'h94, 8'h95,
      8'h98, 8'h99, 8'h9c, 8'hbf, 8'hc0, 8'hc1, 8'hc4, 8'hc5, 8'hc6, 8'hc8,
      8'hca, 8'hcb};
    logic [7:0] even[$] = '{8'hf5, 8'hf6, 8'hf7, 8'hfd};
    foreach (only7[k]) if (only7[k] == ev) return 10'b0010000000;
    foreach (trio[k])  if (trio[k] == ev)  return 10'b0011100000;
    foreach (even[k])  if (even[k] == ev)  return 10'b0001010100;
    if (ev == 8'hf8) return 10'b0011111100;
    if (ev == 8'h8c) return 10'b0010000010;
    if (ev == 8'h02) return 10'b1111111101;
    return 10'b1111111100;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit rq, input logic [7:0] ev, input bit rl,
                      input logic [3:0] ri, input string tag);
    bit ev_ok = 0;
    int ev_i = 0;
    logic [9:0] aff;
    req_valid = rq; req_event = ev; rel_valid = rl; rel_idx = ri;
    aff = ref_aff(ev);
    if (rq)
      for (int i = 0; i < 10; i++)
        if (!ev_ok && aff[i] && !mused[i]) begin ev_ok = 1; ev_i = i; end
    if (rl && ri < 10) mused[ri] = 1'b0;
    if (rq && ev_ok) mused[ev_i] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; rel_valid = 0;
    chk(tag, "gnt_valid", int'(gnt_valid), int'(rq && ev_ok));
    chk(tag, "gnt_fail", int'(gnt_fail), int'(rq && !ev_ok));
    chk(tag, "gnt_idx", int'(gnt_idx), (rq && ev_ok) ? ev_i : 0);
    chk(tag, "used_mask", int'(used_mask), int'(mused));
  endtask

  task automatic free_all();
    for (int i = 0; i < 10; i++) step(0, 0, 1, 4'(i), "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "used_mask", int'(used_mask), 0);
    chk("R1", "gnt_valid", int'(gnt_valid), 0);
    chk("R1", "gnt_fail", int'(gnt_fail), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "used_mask after release", int'(used_mask), 0);
    chk("R1", "gnt_idx after release", int'(gnt_idx), 0);

    // R2 default codes fill 2..9, then fail (R9)
    for (int i = 0; i < 8; i++) step(1, 8'h10, 0, 0, "R2");
    step(1, 8'h33, 0, 0, "R9");
    // R10 out-of-range release ignored
    step(0, 0, 1, 4'd12, "R10");
    step(0, 0, 1, 4'd15, "R10");
    step(0, 0, 1, 4'd5, "R10");
    step(1, 8'h8d, 0, 0, "R5");
    step(1, 8'hc5, 0, 0, "R9");
    free_all();

    // R3 cycle event takes counter 0
    step(1, 8'h02, 0, 0, "R3");
    step(1, 8'h02, 0, 0, "R3");
    // R4 instruction event: 1, then 7, then fail
    step(1, 8'h8c, 0, 0, "R4");
    step(1, 8'h8c, 0, 0, "R4");
    step(1, 8'h8c, 0, 0, "R4");
    // R6 only counter 7 (busy) -> fail; free 7, then grant
    step(1, 8'h9b, 0, 0, "R6");
    step(0, 0, 1, 4'd7, "R10");
    step(1, 8'h01, 0, 0, "R6");
    free_all();

    // R7 subsets
    step(1, 8'hf5, 0, 0, "R7");
    step(1, 8'hfd, 0, 0, "R7");
    step(1, 8'hf6, 0, 0, "R7");
    step(1, 8'hf7, 0, 0, "R7");
    step(1, 8'hf8, 0, 0, "R7");
    step(1, 8'hf8, 0, 0, "R7");
    step(1, 8'hf8, 0, 0, "R7");
    step(1, 8'hf8, 0, 0, "R7");
    // R5 trio
    free_all();
    step(1, 8'h95, 0, 0, "R5");
    step(1, 8'hcb, 0, 0, "R5");
    step(1, 8'h9c, 0, 0, "R5");
    step(1, 8'h90, 0, 0, "R5");

    // R11 same-cycle: release of 7 not visible to a counter-7-only request
    step(1, 8'h97, 1, 4'd7, "R11");
    // R11 same index: grant of 2 while releasing free 2 -> stays set
    free_all();
    step(1, 8'h20, 1, 4'd2, "R11");
    step(1, 8'h20, 1, 4'd2, "R11");

    // R12 idle cycles
    step(0, 8'h02, 0, 0, "R12");
    free_all();

    // R8 mixed traffic
    for (int n = 0; n < 400; n++) begin
      logic [7:0] pool[$] = '{8'h01, 8'h02, 8'h8c, 8'h8d, 8'h96, 8'hc8,
                              8'hf5, 8'hf8, 8'hfd, 8'h44, 8'h00, 8'hff};
      logic [7:0] ev = ($urandom % 3 == 0) ? 8'($urandom) : pool[$urandom % 12];
      step(bit'($urandom % 4 != 0), ev, bit'($urandom % 3 == 0),
           4'($urandom % 12), "R8");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule